// File: doc/BRIEF.md
# Programmable Composite Video Window Generator

This block produces a single enable pulse for a field memory, for example its write enable. The pulse is active inside a rectangle of the incoming video raster. Two counters measure position within the raster. A pixel counter restarts on each rising edge of the horizontal reference sync. A line counter restarts on each rising edge of the vertical reference sync and advances on every horizontal rising edge in between.

Software programs four values through a small parallel write port: a first and a past-the-end position on each axis. Each axis yields a window part from its pair of values. The output is the registered AND of the two parts. Values that are written go into staging registers. They become the working set only on a vertical rising edge, so that a field is never generated from a half-updated window.

Top module: `video_window_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `winEn` is 0. Reset clears both counters and every window value to 0.
- R2: On the clock edge that sees `hRef` high after it was low, the pixel count becomes 0. On every other edge the count increases by one, and it saturates at 2047.
- R3: Each horizontal rising edge increases the line count by one, saturating at 1023. A vertical rising edge sets the line count to 0, and this wins over a coincident increment.
- R4: The horizontal part is true when horizontal start <= pixel count < horizontal stop.
- R5: The vertical part is true when vertical start <= line count < vertical stop. The line count is zero-extended to 11 bits for this compare.
- R6: `winEn` equals the AND of both parts as computed from the state that held one clock earlier, so it has one register of latency.
- R7: An axis whose stop value is less than or equal to its start value keeps `winEn` at 0 for the whole field.
- R8: When `regWrEn` is high at a clock edge, `regWrData` is staged by `regAddr`. The mapping is 0 = horizontal start, 1 = horizontal stop, 2 = vertical start, 3 = vertical stop.
- R9: Staged values are copied into the working set only on a vertical rising edge. A write that lands on that same edge is held until the following vertical rising edge.
- R10: A reference held high does not restart its counter again. Only a low-to-high transition counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| hRef | input | 1 | Horizontal reference sync |
| vRef | input | 1 | Vertical reference sync |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select (0 h start, 1 h stop, 2 v start, 3 v stop) |
| regWrData | input | 11 | Register write value |
| winEn | output | 1 | Composite window enable, registered |

## Verification
Two events can share one clock edge, and each case is provoked on purpose. In the first, a register write arrives on the same edge as a vertical rising edge. The expected result is that the working set takes the old staged value and the new write stays pending for one more field. In the second, a horizontal and a vertical rising edge arrive together. The line count must then restart at 0 instead of advancing. Both cases are judged cycle by cycle: the bench compares `winEn` against a raster position and a working window set that it tracks from the requirements alone.

// File: rtl/vwg_pkg.sv
package vwg_pkg;

  typedef struct packed {
    logic hRise;
    logic vRise;
  } syncStrobes_t;

  typedef enum logic [1:0] {
    SEL_H_FIRST = 2'd0,
    SEL_H_END   = 2'd1,
    SEL_V_FIRST = 2'd2,
    SEL_V_END   = 2'd3
  } regSel_e;

endpackage

// File: rtl/vwg_ctrl.sv
module vwg_ctrl
  import vwg_pkg::*;
#(
  parameter int DATA_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hRef,
  input  logic              vRef,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output syncStrobes_t      strobes,
  output logic [DATA_W-1:0] hFirst,
  output logic [DATA_W-1:0] hEnd,
  output logic [DATA_W-1:0] vFirst,
  output logic [DATA_W-1:0] vEnd
);

  logic hRefQ, vRefQ;
  logic [DATA_W-1:0] stHFirst, stHEnd, stVFirst, stVEnd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hRefQ <= 1'b0;
      vRefQ <= 1'b0;
    end else begin
      hRefQ <= hRef;
      vRefQ <= vRef;
    end
  end

  always_comb begin
    strobes.hRise = hRef & ~hRefQ;
    strobes.vRise = vRef & ~vRefQ;
  end

  // staging registers, written by the host port
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stHFirst <= '0;
      stHEnd   <= '0;
      stVFirst <= '0;
      stVEnd   <= '0;
    end else if (regWrEn) begin
      case (regSel_e'(regAddr))
        SEL_H_FIRST: stHFirst <= regWrData;
        SEL_H_END:   stHEnd   <= regWrData;
        SEL_V_FIRST: stVFirst <= regWrData;
        SEL_V_END:   stVEnd   <= regWrData;
        default:     ;
      endcase
    end
  end

  // working set, refreshed only at a field boundary
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hFirst <= '0;
      hEnd   <= '0;
      vFirst <= '0;
      vEnd   <= '0;
    end else if (strobes.vRise) begin
      hFirst <= stHFirst;
      hEnd   <= stHEnd;
      vFirst <= stVFirst;
      vEnd   <= stVEnd;
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.vRise |=> $stable(hFirst) && $stable(hEnd) && $stable(vFirst) && $stable(vEnd));

  assert_load_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.vRise |=> (hEnd == $past(stHEnd)) && (vEnd == $past(stVEnd)));

  assert_edge_once_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.hRise |=> !strobes.hRise);

endmodule

// File: rtl/vwg_datapath.sv
module vwg_datapath
  import vwg_pkg::*;
#(
  parameter int PIX_W  = 11,
  parameter int LINE_W = 10,
  parameter int DATA_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  syncStrobes_t      strobes,
  input  logic [DATA_W-1:0] hFirst,
  input  logic [DATA_W-1:0] hEnd,
  input  logic [DATA_W-1:0] vFirst,
  input  logic [DATA_W-1:0] vEnd,
  output logic              winEn
);

  localparam logic [PIX_W-1:0]  PIX_MAX  = {PIX_W{1'b1}};
  localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};

  logic [PIX_W-1:0]  pixCnt;
  logic [LINE_W-1:0] lineCnt;
  logic [DATA_W-1:0] pixExt, lineExt;
  logic hPart, vPart;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixCnt <= '0;
    end else if (strobes.hRise) begin
      pixCnt <= '0;
    end else if (pixCnt != PIX_MAX) begin
      pixCnt <= pixCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineCnt <= '0;
    end else if (strobes.vRise) begin
      lineCnt <= '0;
    end else if (strobes.hRise && lineCnt != LINE_MAX) begin
      lineCnt <= lineCnt + 1'b1;
    end
  end

  always_comb begin
    pixExt  = DATA_W'(pixCnt);
    lineExt = DATA_W'(lineCnt);
    hPart   = (pixExt >= hFirst) && (pixExt < hEnd);
    vPart   = (lineExt >= vFirst) && (lineExt < vEnd);
  end

  always_ff @(posedge clk) begin
    if (!rstN) winEn <= 1'b0;
    else       winEn <= hPart & vPart;
  end

  assert_pix_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.hRise |=> pixCnt == '0);

  assert_pix_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.hRise && pixCnt != PIX_MAX) |=> pixCnt == $past(pixCnt) + 1'b1);

  assert_line_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.vRise |=> lineCnt == '0);

  assert_empty_axis_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((hEnd <= hFirst) || (vEnd <= vFirst)) |=> !winEn);

  assert_outside_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pixExt < hFirst) |=> !winEn);

endmodule

// File: rtl/video_window_gen.sv
module video_window_gen
  import vwg_pkg::*;
#(
  parameter int PIX_W  = 11,
  parameter int LINE_W = 10,
  parameter int DATA_W = (PIX_W > LINE_W) ? PIX_W : LINE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hRef,
  input  logic              vRef,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic              winEn
);

  syncStrobes_t strobes;
  logic [DATA_W-1:0] hFirst, hEnd, vFirst, vEnd;

  vwg_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .hRef(hRef), .vRef(vRef),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .strobes(strobes), .hFirst(hFirst), .hEnd(hEnd),
    .vFirst(vFirst), .vEnd(vEnd)
  );

  vwg_datapath #(.PIX_W(PIX_W), .LINE_W(LINE_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .hFirst(hFirst), .hEnd(hEnd), .vFirst(vFirst), .vEnd(vEnd),
    .winEn(winEn)
  );

  assert_reset_out_R1: assert property (@(posedge clk)
    !rstN |=> !winEn);

endmodule

// File: tb/video_window_gen_tb.sv
module video_window_gen_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LINE_LEN   = 24;
  localparam int LINES      = 5;
  localparam int NVEC       = 7;

  // hFirst, hEnd, vFirst, vEnd
  localparam logic [43:0] VEC [NVEC] = '{
    {11'd5,  11'd12, 11'd1, 11'd3},
    {11'd0,  11'd24, 11'd0, 11'd5},
    {11'd10, 11'd10, 11'd1, 11'd3},
    {11'd4,  11'd9,  11'd3, 11'd2},
    {11'd20, 11'd30, 11'd4, 11'd6},
    {11'd0,  11'd1,  11'd0, 11'd1},
    {11'd7,  11'd3,  11'd0, 11'd5}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hRef = 1'b0, vRef = 1'b0, regWrEn = 1'b0;
  logic [1:0] regAddr = '0;
  logic [10:0] regWrData = '0;
  logic winEn;

  int checks = 0;
  int errors = 0;

  // model state derived from the requirements
  int mPix = 0, mLine = 0;
  int sW [4] = '{0, 0, 0, 0};
  int aW [4] = '{0, 0, 0, 0};
  logic mPrevH = 1'b0, mPrevV = 1'b0;

  video_window_gen u_dut (
    .clk(clk), .rstN(rstN), .hRef(hRef), .vRef(vRef),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .winEn(winEn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic ok, input string tag, input logic act, input logic exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s winEn actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic modelWin();
    return (mPix >= aW[0]) && (mPix < aW[1]) && (mLine >= aW[2]) && (mLine < aW[3]);
  endfunction

  // one clock with given inputs, checked against the model (R2..R10)
  task automatic tick(input logic h, input logic v, input logic we,
                      input logic [1:0] a, input logic [10:0] d, input string tag);
    logic exp, hr, vr;
    hRef = h; vRef = v; regWrEn = we; regAddr = a; regWrData = d;
    exp = modelWin();
    hr = h && !mPrevH;
    vr = v && !mPrevV;
    if (vr) aW = sW;
    if (we) sW[a] = int'(d);
    if (hr) mPix = 0; else if (mPix != 2047) mPix++;
    if (vr) mLine = 0; else if (hr && mLine != 1023) mLine++;
    mPrevH = h; mPrevV = v;
    @(posedge clk);
    @(negedge clk);
    check(winEn === exp, tag, winEn, exp);
  endtask

  task automatic writeAll(input logic [43:0] cfg);
    tick(0, 0, 1, 2'd0, cfg[43:33], "R8");
    tick(0, 0, 1, 2'd1, cfg[32:22], "R8");
    tick(0, 0, 1, 2'd2, cfg[21:11], "R8");
    tick(0, 0, 1, 2'd3, cfg[10:0],  "R8");
  endtask

  task automatic frame(input int nLines, input int len, input string tag);
    for (int l = 0; l < nLines; l++) begin
      tick(1, (l == 0), 0, 2'd0, 11'd0, tag);
      for (int p = 1; p < len; p++) tick(0, 0, 0, 2'd0, 11'd0, tag);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int hits;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(winEn === 1'b0, "R1", winEn, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    check(winEn === 1'b0, "R1", winEn, 1'b0);

    // table walk: R4 R5 R6 R7 R8 R9
    for (int i = 0; i < NVEC; i++) begin
      writeAll(VEC[i]);
      frame(LINES, LINE_LEN, "R4_R5_R6_R7");
    end

    // R9: write on the same edge as a vertical rise stays pending
    writeAll({11'd0, 11'd24, 11'd0, 11'd5});
    frame(1, LINE_LEN, "R9");
    tick(1, 1, 1, 2'd1, 11'd0, "R9");
    for (int p = 1; p < LINE_LEN; p++) tick(0, 0, 0, 2'd0, 11'd0, "R9");
    frame(2, LINE_LEN, "R9");

    // R3: coincident horizontal and vertical rise restarts line count
    writeAll({11'd0, 11'd24, 11'd0, 11'd1});
    frame(3, LINE_LEN, "R3");

    // R10: horizontal reference held high does not restart counting
    writeAll({11'd30, 11'd32, 11'd0, 11'd1});
    tick(1, 1, 0, 2'd0, 11'd0, "R10");
    hits = 0;
    for (int p = 0; p < 40; p++) begin
      tick(1, 0, 0, 2'd0, 11'd0, "R10");
      if (winEn) hits++;
    end
    checks++;
    if (hits != 2) begin errors++; $display("FAIL R10 hits actual=%0d expected=2", hits); end

    // R2: pixel count saturation, one position active at 2046
    writeAll({11'd2046, 11'd2047, 11'd0, 11'd1});
    tick(1, 0, 0, 2'd0, 11'd0, "R2");
    tick(0, 0, 0, 2'd0, 11'd0, "R2");
    tick(1, 1, 0, 2'd0, 11'd0, "R2");
    hits = 0;
    for (int p = 0; p < 2100; p++) begin
      tick(0, 0, 0, 2'd0, 11'd0, "R2");
      if (winEn) hits++;
    end
    checks++;
    if (hits != 1) begin errors++; $display("FAIL R2 hits actual=%0d expected=1", hits); end

    // R3: line count saturation at 1023
    writeAll({11'd0, 11'd2, 11'd1022, 11'd1024});
    tick(0, 1, 0, 2'd0, 11'd0, "R3");
    tick(0, 0, 0, 2'd0, 11'd0, "R3");
    tick(1, 1, 0, 2'd0, 11'd0, "R3");
    tick(0, 0, 0, 2'd0, 11'd0, "R3");
    hits = 0;
    for (int l = 0; l < 1100; l++) begin
      tick(1, 0, 0, 2'd0, 11'd0, "R3");
      if (winEn) hits++;
      tick(0, 0, 0, 2'd0, 11'd0, "R3");
      if (winEn) hits++;
    end
    checks++;
    if (hits < 4) begin errors++; $display("FAIL R3 hits actual=%0d expected>=4", hits); end

    // R1: reset mid-frame returns output low
    rstN = 1'b0;
    @(negedge clk);
    check(winEn === 1'b0, "R1", winEn, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule